// File: doc/BRIEF.md
# Charger Status LED Pattern Generator

This block turns a two-bit charge-status code into the drive for one open-drain status LED. It supports three display styles, chosen once after reset from a decoded two-bit select. In each style, every status maps to one of three outputs: the pin released, the pin held low, or a timed blink. Blink timing is counted in ticks of an external strobe that pulses once every 10 ms. With the default lengths, the long interval is 0.80 s, the medium interval is 0.48 s and the short interval is 0.16 s.

The output is an active-high pull-low enable. A 1 turns on the open-drain pull-down and a 0 leaves the pin at high impedance. The status input is registered on every clock. When the code changes, the blink pattern starts again at the beginning of its low phase. Sampling the tri-state pins and running the charge state machine are done elsewhere.

Top module: `ledpat_top`

## Requirements
- R1: Status code 0 (no battery) keeps `ledPullLow` at 0 in every display mode.
- R2: Status code 1 (charging) drives `ledPullLow` at 1 steadily in modes 0 and 1. In mode 2 it blinks: LONG_TICKS ticks at 1, then SHORT_TICKS ticks at 0, repeating.
- R3: Status code 2 (maintenance) has a different output in each mode. In mode 0 it blinks LONG_TICKS at 1, then SHORT_TICKS at 0. In mode 1 it holds 0. In mode 2 it holds 1.
- R4: Status code 3 (fault) blinks in every mode. In mode 0 it gives MID_TICKS at 1, then MID_TICKS at 0. In modes 1 and 2 it gives SHORT_TICKS at 1, then SHORT_TICKS at 0.
- R5: The mode select is captured at the first clock edge after reset is released. Select value 0 gives mode 0, 1 gives mode 1, 2 gives mode 2, and 3 is also treated as mode 2. Later changes on the select have no effect until the next reset.
- R6: The output follows the status sampled at the previous clock edge. An edge that samples a new status code, or the edge that captures the mode, restarts the pattern at the first tick of its low phase. A tick present at that same edge is not counted.
- R7: Blink intervals advance only on clock edges where `tick` is 1. Clock cycles without a tick hold the output and the position in the pattern.
- R8: While reset is asserted, and in the first cycle after reset is released (before the mode is captured), `ledPullLow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one cycle wide, nominally every 10 ms |
| modeSel | input | 2 | Decoded display-mode select (0, 1, 2; 3 is treated as 2) |
| chgStatus | input | 2 | Charge status: 0 none, 1 charging, 2 maintenance, 3 fault |
| ledPullLow | output | 1 | 1 turns the LED pull-down on, 0 leaves the pin at high impedance |

## Verification
The bench builds the block with LONG_TICKS=7, MID_TICKS=4 and SHORT_TICKS=2. These values are distinct and small, so every blink shape completes many full periods within a few dozen cycles. With them, the bench can sweep all four select values against all four status codes, in status sequences that change the code part-way through a phase. Segments where a tick arrives only every third cycle show that the pattern position holds between ticks. For every cycle, the expected output is computed as the tick count since the last restart, taken modulo the period and compared with the low-phase length.

// File: rtl/ledpat_pkg.sv
package ledpat_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_MAINT  = 2'd2,
    ST_FAULT  = 2'd3
  } chgStatusE;

  typedef enum logic [1:0] {
    DM_ZERO = 2'd0,
    DM_ONE  = 2'd1,
    DM_TWO  = 2'd2
  } dispModeE;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'd0,
    PAT_ON    = 2'd1,
    PAT_BLINK = 2'd2
  } patKindE;

  typedef enum logic [1:0] {
    LEN_LONG  = 2'd0,
    LEN_MID   = 2'd1,
    LEN_SHORT = 2'd2
  } lenSelE;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   restart;
    logic   advance;
    lenSelE lowSel;
    lenSelE highSel;
  } patStrobeT;

endpackage

// File: rtl/ledpat_ctrl.sv
module ledpat_ctrl
  import ledpat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] modeIn,
  input  logic [1:0] statusIn,
  input  logic       phaseLow,
  output patStrobeT  strobe,
  output logic       ledPullLow,
  output dispModeE   modeQ,
  output logic       modeLatched,
  output chgStatusE  statusQ
);

  patKindE patKind;
  lenSelE  lowSel;
  lenSelE  highSel;

  function automatic dispModeE decodeMode(input logic [1:0] raw);
    case (raw)
      2'd0:    decodeMode = DM_ZERO;
      2'd1:    decodeMode = DM_ONE;
      default: decodeMode = DM_TWO;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ       <= DM_ZERO;
      modeLatched <= 1'b0;
      statusQ     <= ST_NONE;
    end else begin
      if (!modeLatched) begin
        modeQ       <= decodeMode(modeIn);
        modeLatched <= 1'b1;
      end
      statusQ <= chgStatusE'(statusIn);
    end
  end

  // Pattern table: status x mode
  always_comb begin
    patKind = PAT_OFF;
    lowSel  = LEN_LONG;
    highSel = LEN_SHORT;
    case (statusQ)
      ST_NONE: patKind = PAT_OFF;
      ST_CHARGE: begin
        patKind = (modeQ == DM_TWO) ? PAT_BLINK : PAT_ON;
      end
      ST_MAINT: begin
        case (modeQ)
          DM_ZERO: patKind = PAT_BLINK;
          DM_ONE:  patKind = PAT_OFF;
          default: patKind = PAT_ON;
        endcase
      end
      ST_FAULT: begin
        patKind = PAT_BLINK;
        if (modeQ == DM_ZERO) begin
          lowSel  = LEN_MID;
          highSel = LEN_MID;
        end else begin
          lowSel  = LEN_SHORT;
          highSel = LEN_SHORT;
        end
      end
      default: patKind = PAT_OFF;
    endcase
  end

  always_comb begin
    strobe.restart = !modeLatched || (statusIn != 2'(statusQ));
    strobe.advance = tick && (patKind == PAT_BLINK);
    strobe.lowSel  = lowSel;
    strobe.highSel = highSel;
    ledPullLow     = modeLatched &&
                     ((patKind == PAT_ON) || ((patKind == PAT_BLINK) && phaseLow));
  end

endmodule

// File: rtl/ledpat_dp.sv
module ledpat_dp
  import ledpat_pkg::*;
#(
  parameter int LONG_TICKS  = 80,
  parameter int MID_TICKS   = 48,
  parameter int SHORT_TICKS = 16,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  patStrobeT        strobe,
  output logic             phaseLow,
  output logic [CNT_W-1:0] phaseCnt,
  output logic [CNT_W-1:0] curLen
);

  function automatic logic [CNT_W-1:0] lenOf(input lenSelE sel);
    case (sel)
      LEN_LONG: lenOf = CNT_W'(LONG_TICKS);
      LEN_MID:  lenOf = CNT_W'(MID_TICKS);
      default:  lenOf = CNT_W'(SHORT_TICKS);
    endcase
  endfunction

  assign curLen = phaseLow ? lenOf(strobe.lowSel) : lenOf(strobe.highSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseLow <= 1'b1;
    end else if (strobe.restart) begin
      phaseCnt <= '0;
      phaseLow <= 1'b1;
    end else if (strobe.advance) begin
      if (phaseCnt == curLen - CNT_W'(1)) begin
        phaseCnt <= '0;
        phaseLow <= !phaseLow;
      end else begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ledpat_top.sv
module ledpat_top
  import ledpat_pkg::*;
#(
  parameter int LONG_TICKS  = 80,
  parameter int MID_TICKS   = 48,
  parameter int SHORT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] modeSel,
  input  logic [1:0] chgStatus,
  output logic       ledPullLow
);

  localparam int MAX_A = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int MAX_LEN = (MAX_A > SHORT_TICKS) ? MAX_A : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  patStrobeT        strobe;
  logic             phaseLow;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] curLen;
  dispModeE         modeQ;
  logic             modeLatched;
  chgStatusE        statusQ;

  ledpat_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .modeIn      (modeSel),
    .statusIn    (chgStatus),
    .phaseLow    (phaseLow),
    .strobe      (strobe),
    .ledPullLow  (ledPullLow),
    .modeQ       (modeQ),
    .modeLatched (modeLatched),
    .statusQ     (statusQ)
  );

  ledpat_dp #(
    .LONG_TICKS  (LONG_TICKS),
    .MID_TICKS   (MID_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .phaseLow (phaseLow),
    .phaseCnt (phaseCnt),
    .curLen   (curLen)
  );

endmodule

// File: rtl/ledpat_chk.sv
module ledpat_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       chgStatus,
  input logic             ledPullLow,
  input logic [1:0]       modeQ,
  input logic             modeLatched,
  input logic [1:0]       statusQ,
  input logic [CNT_W-1:0] phaseCnt,
  input logic [CNT_W-1:0] curLen
);

  p_none_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    (chgStatus == 2'd0) |=> !ledPullLow);

  p_charge_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatched && modeQ != 2'd2 && chgStatus == 2'd1) |=> ledPullLow);

  p_maint_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatched && modeQ == 2'd1 && chgStatus == 2'd2) |=> !ledPullLow);

  p_maint_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatched && modeQ == 2'd2 && chgStatus == 2'd2) |=> ledPullLow);

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeLatched |=> (modeLatched && $stable(modeQ)));

  p_restart_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chgStatus == 2'd3 && (statusQ != 2'd3 || !modeLatched)) |=> ledPullLow);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < curLen);

  p_unlatched_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeLatched |-> !ledPullLow);

endmodule

bind ledpat_top ledpat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .chgStatus   (chgStatus),
  .ledPullLow  (ledPullLow),
  .modeQ       (modeQ),
  .modeLatched (modeLatched),
  .statusQ     (statusQ),
  .phaseCnt    (phaseCnt),
  .curLen      (curLen)
);

// File: tb/ledpat_top_bench.sv
`timescale 1ns/1ps
module ledpat_top_bench;

  localparam int L = 7;
  localparam int M = 4;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [1:0] chgStatus = 2'd0;
  logic ledPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit mLatched;
  int mMode;
  int mStatus;
  int n;
  bit justRestart;
  bit gapped;
  int origMode;

  always #2.5 clk = ~clk;

  ledpat_top #(.LONG_TICKS(L), .MID_TICKS(M), .SHORT_TICKS(S)) u_ledpat_top (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .modeSel    (modeSel),
    .chgStatus  (chgStatus),
    .ledPullLow (ledPullLow)
  );

  function automatic bit blinkAt(int lo, int hi, int pos);
    return (pos % (lo + hi)) < lo;
  endfunction

  function automatic bit expOut();
    if (!mLatched) return 1'b0;
    case (mStatus)
      0: return 1'b0;
      1: return (mMode < 2) ? 1'b1 : blinkAt(L, S, n);
      2: begin
        if (mMode == 0) return blinkAt(L, S, n);
        else if (mMode == 1) return 1'b0;
        else return 1'b1;
      end
      default: return (mMode == 0) ? blinkAt(M, M, n) : blinkAt(S, S, n);
    endcase
  endfunction

  function automatic string tagFor();
    string t;
    case (mStatus)
      0: t = "R1 none";
      1: t = "R2 charge";
      2: t = "R3 maint";
      default: t = "R4 fault";
    endcase
    if (mLatched) t = {t, " R5 held"};
    if (justRestart) t = {t, " R6 restart"};
    if (gapped) t = {t, " R7 gapped"};
    return t;
  endfunction

  task automatic check(string tag, bit expv);
    checks++;
    if (ledPullLow !== expv) begin
      errors++;
      $display("FAIL %s mode=%0d: ledPullLow=%0b expected %0b", tag, mMode, ledPullLow, expv);
    end
  endtask

  // entered and left at a falling edge
  task automatic runSeg(int st, int cycles, bit gap);
    for (int k = 0; k < cycles; k++) begin
      chgStatus = 2'(st);
      tick = gap ? (k % 3 == 1) : 1'b1;
      modeSel = mLatched ? ~2'(origMode) : 2'(origMode);
      @(posedge clk);
      #1;
      if (!mLatched) begin
        mLatched = 1'b1;
        mMode = (origMode == 3) ? 2 : origMode;
        mStatus = st;
        n = 0;
        justRestart = 1'b1;
      end else if (st != mStatus) begin
        mStatus = st;
        n = 0;
        justRestart = 1'b1;
      end else begin
        justRestart = 1'b0;
        if (tick) n++;
      end
      gapped = gap;
      @(negedge clk);
      check(tagFor(), expOut());
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      origMode = m;
      @(negedge clk);
      rstN = 1'b0;
      modeSel = 2'(m);
      chgStatus = 2'd1;
      tick = 1'b1;
      mLatched = 1'b0;
      mMode = 0;
      mStatus = 0;
      n = 0;
      justRestart = 1'b0;
      gapped = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 in reset", 1'b0);
      rstN = 1'b1;
      #1;
      check("R8 before mode capture", 1'b0);
      runSeg(1, 30, 1'b0);
      runSeg(2, 30, 1'b1);
      runSeg(3, 25, 1'b0);
      runSeg(0, 6, 1'b0);
      runSeg(3, 12, 1'b1);
      runSeg(1, 9, 1'b0);
      runSeg(2, 20, 1'b0);
      runSeg(3, 5, 1'b0);
      runSeg(2, 5, 1'b0);
      runSeg(1, 3, 1'b0);
      runSeg(3, 3, 1'b0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule